// File: doc/BRIEF.md
# Indirect Readback Byte Selector

This block is the read side of an 8-bit processor port into a signal-processing core. Readback takes two steps. The processor first writes a small source code to one fixed address. That write also freezes a copy of the chosen source. Later reads then use the 3-bit bus address to pick one byte of the frozen copy. A multi-byte quantity read over several bus cycles therefore always comes from one sample.

Four sources can be selected:
- the in-phase/quadrature sample pair;
- the polar magnitude/phase pair;
- a frequency word;
- a 24-bit input level value.

One reserved address skips the code step and returns a live status byte at once. The block sits behind the chip's pad ring. It hands the pad a byte and an output enable, and the enable follows the active-low read strobe.

Top module: `rb_byte_sel`

## Requirements
- R1: While `rst` is high, and until the first code write, the held code is 000, the frozen copy is zero and `data_oe` is low. A read of any address other than 7 returns 0x00 in that state.
- R2: A write commits on the clock edge where `wr_n` is sampled high after being sampled low, with `addr` = 5. It loads `data_i[2:0]` as the source code and ignores `data_i[7:3]`. A write completed at any other address changes neither the code nor the frozen copy.
- R3: `data_oe` rises on the first clock edge at which `rd_n` is sampled low. It falls on the first edge at which `rd_n` is sampled high.
- R4: Code 000 selects the sample pair. Address 0 returns I[7:0], 1 returns I[15:8], 2 returns Q[7:0] and 3 returns Q[15:8]. Addresses 4 to 6 return 0x00.
- R5: Code 001 selects the polar pair. Address 0 returns magnitude[7:0], 1 returns magnitude[15:8], 2 returns phase[7:0] and 3 returns phase[15:8]. Addresses 4 to 6 return 0x00.
- R6: Code 010 selects the frequency word. Address 0 returns bits 7:0 and address 1 returns bits 15:8. Addresses 2 to 6 return 0x00.
- R7: Code 100 selects the level value. Addresses 0, 1 and 2 return bits 7:0, 15:8 and 23:16. Addresses 3 to 6 return 0x00.
- R8: Address 7 returns the current `status` input whatever the held code is.
- R9: Codes 011, 101, 110 and 111 return 0x00 at addresses 0 to 6.
- R10: Bytes come from the copy frozen at the last code write. Later changes on the source inputs have no effect until the next code write.
- R11: While `rd_n` stays low, `data_o` is updated on every clock edge from the address present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Bus address |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| data_i | input | 8 | Bus data from the processor |
| data_o | output | 8 | Bus data to the pad |
| data_oe | output | 1 | Pad output enable |
| smp_i | input | 16 | In-phase sample |
| smp_q | input | 16 | Quadrature sample |
| pol_mag | input | 16 | Polar magnitude |
| pol_phase | input | 16 | Polar phase |
| freq_word | input | 16 | Frequency word |
| lvl_word | input | 24 | Input level value |
| status | input | 8 | Live status byte |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 16-bit samples, a 24-bit level word, code address 5 and status address 7. These values make the frozen copy exactly four bytes wide. That puts the edge of every source's byte range within reach: the last valid address of each code and the first address that must read zero. The live status path and the unused codes can then be compared against the same address space.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Source codes loaded by a code write; values are decoded by behaviour.
  localparam logic [2:0] SRC_IQ    = 3'b000;
  localparam logic [2:0] SRC_POLAR = 3'b001;
  localparam logic [2:0] SRC_FREQ  = 3'b010;
  localparam logic [2:0] SRC_LEVEL = 3'b100;
  localparam int CODE_W = 3;
endpackage

// File: rtl/rb_code_latch.sv
module rb_code_latch
  import rb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int SAMPLE_W  = 16,
  parameter int LEVEL_W   = 24,
  parameter int CODE_ADDR = 5,
  parameter int HOLD_W    = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] smp_q,
  input  logic [SAMPLE_W-1:0] pol_mag,
  input  logic [SAMPLE_W-1:0] pol_phase,
  input  logic [SAMPLE_W-1:0] freq_word,
  input  logic [LEVEL_W-1:0]  lvl_word,
  output logic [CODE_W-1:0]   code_o,
  output logic [HOLD_W-1:0]   hold_o
);
  logic              wr_q;
  logic              commit;
  logic [CODE_W-1:0] new_code;
  logic [HOLD_W-1:0] snap;

  assign new_code = data_i[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  // Commit on the trailing (rising) edge of the write strobe.
  assign commit = wr_n && !wr_q && (addr == ADDR_W'(CODE_ADDR));

  always_comb begin
    case (new_code)
      SRC_IQ:    snap = {smp_q, smp_i};
      SRC_POLAR: snap = {pol_phase, pol_mag};
      SRC_FREQ:  snap = HOLD_W'(freq_word);
      SRC_LEVEL: snap = HOLD_W'(lvl_word);
      default:   snap = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= SRC_IQ;
      hold_o <= '0;
    end else if (commit) begin
      code_o <= new_code;
      hold_o <= snap;
    end
  end

  p_code_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(code_o));
  p_code_load_r2: assert property (@(posedge clk) disable iff (rst)
    commit |=> code_o == $past(data_i[CODE_W-1:0]));
  p_snap_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(hold_o));
endmodule

// File: rtl/rb_byte_mux.sv
module rb_byte_mux
  import rb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SAMPLE_W    = 16,
  parameter int LEVEL_W     = 24,
  parameter int STATUS_ADDR = 7,
  parameter int HOLD_W      = 2 * SAMPLE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HOLD_W-1:0] hold,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] byte_o
);
  localparam int NLANE       = HOLD_W / DATA_W;
  localparam int PAIR_LANES  = (2 * SAMPLE_W) / DATA_W;
  localparam int WORD_LANES  = SAMPLE_W / DATA_W;
  localparam int LEVEL_LANES = (LEVEL_W + DATA_W - 1) / DATA_W;

  logic [DATA_W-1:0] lane [NLANE];
  int                limit;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane[g] = hold[g*DATA_W +: DATA_W];
  end

  always_comb begin
    case (code)
      SRC_IQ, SRC_POLAR: limit = PAIR_LANES;
      SRC_FREQ:          limit = WORD_LANES;
      SRC_LEVEL:         limit = LEVEL_LANES;
      default:           limit = 0;
    endcase
  end

  always_comb begin
    byte_o = '0;
    if (addr == ADDR_W'(STATUS_ADDR)) begin
      byte_o = status;
    end else begin
      for (int k = 0; k < NLANE; k++) begin
        if (addr == ADDR_W'(k) && k < limit) byte_o = lane[k];
      end
    end
  end
endmodule

// File: rtl/rb_bus_drv.sv
module rb_bus_drv #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe <= 1'b0;
      data_o  <= '0;
    end else begin
      data_oe <= !rd_n;
      if (!rd_n) data_o <= byte_i;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !data_oe);
  p_oe_on_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> data_oe);
  p_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
    rd_n |=> !data_oe);
endmodule

// File: rtl/rb_byte_sel.sv
module rb_byte_sel
  import rb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SAMPLE_W    = 16,
  parameter int LEVEL_W     = 24,
  parameter int CODE_ADDR   = 5,
  parameter int STATUS_ADDR = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                data_oe,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] smp_q,
  input  logic [SAMPLE_W-1:0] pol_mag,
  input  logic [SAMPLE_W-1:0] pol_phase,
  input  logic [SAMPLE_W-1:0] freq_word,
  input  logic [LEVEL_W-1:0]  lvl_word,
  input  logic [DATA_W-1:0]   status
);
  localparam int HOLD_W = 2 * SAMPLE_W;

  logic [CODE_W-1:0] code;
  logic [HOLD_W-1:0] hold;
  logic [DATA_W-1:0] sel_byte;

  rb_code_latch #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W),
    .LEVEL_W(LEVEL_W), .CODE_ADDR(CODE_ADDR), .HOLD_W(HOLD_W)
  ) u_latch (
    .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .data_i(data_i),
    .smp_i(smp_i), .smp_q(smp_q), .pol_mag(pol_mag), .pol_phase(pol_phase),
    .freq_word(freq_word), .lvl_word(lvl_word),
    .code_o(code), .hold_o(hold)
  );

  rb_byte_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W),
    .LEVEL_W(LEVEL_W), .STATUS_ADDR(STATUS_ADDR), .HOLD_W(HOLD_W)
  ) u_mux (
    .code(code), .addr(addr), .hold(hold), .status(status), .byte_o(sel_byte)
  );

  rb_bus_drv #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst(rst), .rd_n(rd_n), .byte_i(sel_byte),
    .data_o(data_o), .data_oe(data_oe)
  );

  p_status_live_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && addr == ADDR_W'(STATUS_ADDR)) |=> data_o == $past(status));
endmodule

// File: tb/test_rb_byte_sel.sv
`timescale 1ns/1ps
module test_rb_byte_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe;
  logic [15:0] smp_i = '0, smp_q = '0, pol_mag = '0, pol_phase = '0, freq_word = '0;
  logic [23:0] lvl_word = '0;
  logic [7:0]  status = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model of the frozen copy and held code
  logic [2:0]  m_code = 3'b000;
  logic [15:0] m_i = '0, m_q = '0, m_mag = '0, m_ph = '0, m_fr = '0;
  logic [23:0] m_lv = '0;

  always #2.5 clk = ~clk;

  rb_byte_sel i_rb_byte_sel (
    .clk(clk), .rst(rst), .addr(addr), .wr_n(wr_n), .rd_n(rd_n),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .smp_i(smp_i), .smp_q(smp_q), .pol_mag(pol_mag), .pol_phase(pol_phase),
    .freq_word(freq_word), .lvl_word(lvl_word), .status(status)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [2:0] a);
    logic [31:0] w;
    int n;
    if (a == 3'd7) return status;
    case (m_code)
      3'b000:  begin w = {m_q, m_i};        n = 4; end
      3'b001:  begin w = {m_ph, m_mag};     n = 4; end
      3'b010:  begin w = {16'h0, m_fr};     n = 2; end
      3'b100:  begin w = {8'h0, m_lv};      n = 3; end
      default: begin w = '0;                n = 0; end
    endcase
    if (int'(a) >= n) return 8'h00;
    return w[8*a +: 8];
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data_i = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); data_i = '0;
    if (a == 3'd5) begin
      m_code = d[2:0];
      m_i = smp_i; m_q = smp_q; m_mag = pol_mag; m_ph = pol_phase;
      m_fr = freq_word; m_lv = lvl_word;
    end
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_n = 1'b0;
    @(negedge clk); v = data_o; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sweep(input string req, input int last);
    logic [7:0] v;
    for (int a = 0; a <= last; a++) begin
      bus_rd(3'(a), v);
      check(req, v, exp_byte(3'(a)));
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 oe after reset", {7'b0, data_oe}, 8'h00);
    smp_i = 16'h1357; smp_q = 16'h2468;
    bus_rd(3'd0, v); check("R1 cleared copy addr0", v, 8'h00);
    bus_rd(3'd2, v); check("R1 cleared copy addr2", v, 8'h00);
  endtask

  task automatic t_iq();
    smp_i = 16'hA1B2; smp_q = 16'hC3D4;
    bus_wr(3'd5, 8'h00);
    sweep("R4 sample pair", 6);
  endtask

  task automatic t_polar();
    pol_mag = 16'h5E6F; pol_phase = 16'h7081;
    bus_wr(3'd5, 8'h01);
    sweep("R5 polar pair", 6);
  endtask

  task automatic t_freq();
    freq_word = 16'h9ABC;
    bus_wr(3'd5, 8'h02);
    sweep("R6 frequency", 6);
  endtask

  task automatic t_level();
    lvl_word = 24'h321AF5;
    bus_wr(3'd5, 8'h04);
    sweep("R7 level", 6);
  endtask

  task automatic t_status();
    logic [7:0] v;
    status = 8'h3C;
    bus_wr(3'd5, 8'h01);
    bus_rd(3'd7, v); check("R8 status code 001", v, 8'h3C);
    status = 8'hC5;
    bus_rd(3'd7, v); check("R8 status follows input", v, 8'hC5);
    bus_wr(3'd5, 8'h03);
    bus_rd(3'd7, v); check("R8 status code 011", v, 8'hC5);
  endtask

  task automatic t_unused();
    for (int c = 3; c <= 7; c++) begin
      if (c == 4) continue;
      bus_wr(3'd5, 8'(c));
      sweep("R9 unused code", 6);
    end
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    smp_i = 16'h0F1E; smp_q = 16'h2D3C;
    bus_wr(3'd5, 8'h00);
    smp_i = 16'hFFFF;
    bus_wr(3'd4, 8'h01);
    bus_rd(3'd0, v); check("R2 other address ignored", v, 8'h1E);
    bus_rd(3'd1, v); check("R2 other address ignored hi", v, 8'h0F);
    pol_mag = 16'h4455;
    bus_wr(3'd5, 8'hF9);
    bus_rd(3'd0, v); check("R2 upper data bits ignored", v, 8'h55);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    lvl_word = 24'hABCDEF;
    bus_wr(3'd5, 8'h04);
    lvl_word = 24'h010203;
    bus_rd(3'd0, v); check("R10 frozen byte0", v, 8'hEF);
    bus_rd(3'd2, v); check("R10 frozen byte2", v, 8'hAB);
    bus_wr(3'd5, 8'h04);
    bus_rd(3'd2, v); check("R10 refreshed byte2", v, 8'h01);
  endtask

  task automatic t_oe();
    @(negedge clk); addr = 3'd0; rd_n = 1'b0;
    check("R3 oe before edge", {7'b0, data_oe}, 8'h00);
    @(negedge clk);
    check("R3 oe after low sample", {7'b0, data_oe}, 8'h01);
    rd_n = 1'b1;
    check("R3 oe held until edge", {7'b0, data_oe}, 8'h01);
    @(negedge clk);
    check("R3 oe after high sample", {7'b0, data_oe}, 8'h00);
  endtask

  task automatic t_follow();
    smp_i = 16'h8877; smp_q = 16'h6655;
    bus_wr(3'd5, 8'h00);
    @(negedge clk); addr = 3'd0; rd_n = 1'b0;
    for (int a = 1; a <= 4; a++) begin
      @(negedge clk);
      check("R11 byte follows address", data_o, exp_byte(3'(a - 1)));
      addr = 3'(a);
    end
    @(negedge clk);
    check("R11 last address", data_o, exp_byte(3'd4));
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_iq();
    t_polar();
    t_freq();
    t_level();
    t_status();
    t_unused();
    t_ignore();
    t_snapshot();
    t_oe();
    t_follow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule